// File: doc/BRIEF.md
# Eight-Bit Accumulator Arithmetic and Logic Unit

This block computes one arithmetic or logic step for an 8-bit accumulator machine. An accumulator byte, a second operand byte, a 3-bit operation select and the current carry flag go in. A result byte and a fresh flag byte come out. The selectable operations are add, add with carry, subtract, subtract with borrow, bitwise AND, XOR and OR, and compare. Compare is a subtraction whose only effect is on the flags. For compare the block passes the accumulator through unchanged and lowers its write-back indication.

The computation is combinational. A thin registered wrapper captures the result one clock after a valid input and holds it until the next valid input. The flag byte packs sign, zero, half-carry, parity/overflow, subtract and carry into fixed bit positions so that a neighbouring condition decoder can read them directly.

Top module: `accum_alu`

## Requirements
- R1: Select code 0 is add. The result is (acc + opnd) mod 256 and C is the carry out of bit 7. The incoming carry has no effect on this operation.
- R2: Select code 1 is add with carry. The result is (acc + opnd + carryIn) mod 256 and C is the carry out of bit 7.
- R3: Select code 2 is subtract and select code 3 is subtract with borrow. The result is (acc - opnd) mod 256 for code 2 and (acc - opnd - carryIn) mod 256 for code 3. C is set when a borrow leaves bit 7. Code 2 ignores carryIn.
- R4: Select codes 4, 5 and 6 give bitwise AND, XOR and OR. For these codes C is 0 and P/V is 1 exactly when the result has an even number of one bits. H is 1 for AND and 0 for XOR and OR.
- R5: Select code 7 is compare. Its flags are those of subtract on the same operands. resultOut equals the accumulator input, and writeBack is 0. For every other code writeBack is 1.
- R6: For the four arithmetic codes and compare, P/V is 1 exactly when the signed two's-complement result overflows.
- R7: For the arithmetic codes and compare, H is the carry (add) or borrow (subtract) out of bit 3.
- R8: N is 1 for codes 2, 3 and 7 and 0 for all other codes.
- R9: S equals bit 7 of the computed result and Z is 1 when the computed 8-bit result is zero. For compare this is the subtraction result.
- R10: Flag byte layout: bit 7 S, bit 6 Z, bit 4 H, bit 2 P/V, bit 1 N, bit 0 C. Bits 5 and 3 are always 0.
- R11: outValid is high in the cycle after a cycle with inValid high, and is low otherwise. resultOut, flagsOut and writeBack change only on a captured input.
- R12: While rstN is low, outValid, resultOut, flagsOut and writeBack are all 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| inValid | input | 1 | Operands and select are valid this cycle |
| accIn | input | 8 | Accumulator operand |
| opndIn | input | 8 | Second operand |
| opSel | input | 3 | Operation select, codes 0 to 7 |
| carryIn | input | 1 | Current carry flag |
| outValid | output | 1 | Registered outputs updated last cycle |
| resultOut | output | 8 | Result, or the unchanged accumulator for compare |
| flagsOut | output | 8 | Flag byte in the layout of R10 |
| writeBack | output | 1 | Result should be written to the accumulator |

## Verification
The bench builds the block with its default data width of 8, so the nibble boundary for half-carry sits at bit 4. The signed limits 0x7F and 0x80 and the unsigned wrap at 0xFF are all reachable with single vectors. That lets each vector hit one chosen corner: overflow into the sign bit, borrow through zero, a zero result that produces a carry, and parity on both even and odd bit counts. Carry-in is driven high on the codes that must ignore it, so a design that leaks it changes a visible result.

// File: rtl/accum_alu_pkg.sv
`timescale 1ns/1ps
package accum_alu_pkg;

  typedef enum logic [2:0] {
    OP_ADD = 3'd0,
    OP_ADC = 3'd1,
    OP_SUB = 3'd2,
    OP_SBC = 3'd3,
    OP_AND = 3'd4,
    OP_XOR = 3'd5,
    OP_OR  = 3'd6,
    OP_CMP = 3'd7
  } aluOp_e;

  typedef enum logic [1:0] {
    LG_AND = 2'd0,
    LG_XOR = 2'd1,
    LG_OR  = 2'd2
  } logicFn_e;

  // strobes from the decoder to the datapath
  typedef struct packed {
    logic     invertB;   // subtract: complement operand and carry sense
    logic     carryEn;   // fold the incoming carry into the sum
    logic     logicPath; // take the bitwise unit instead of the adder
    logicFn_e logicFn;
    logic     writeEn;   // result is written back
  } ctrlStrobe_t;

  localparam int FLAG_W = 8;
  localparam int FLG_S  = 7;
  localparam int FLG_Z  = 6;
  localparam int FLG_H  = 4;
  localparam int FLG_PV = 2;
  localparam int FLG_N  = 1;
  localparam int FLG_C  = 0;

endpackage

// File: rtl/accum_alu_ctrl.sv
`timescale 1ns/1ps
module accum_alu_ctrl
  import accum_alu_pkg::*;
(
  input  logic [2:0]  opSel,
  output ctrlStrobe_t strobe
);

  always_comb begin
    strobe = '{invertB: 1'b0, carryEn: 1'b0, logicPath: 1'b0,
               logicFn: LG_AND, writeEn: 1'b1};
    case (aluOp_e'(opSel))
      OP_ADD: ;
      OP_ADC: strobe.carryEn = 1'b1;
      OP_SUB: strobe.invertB = 1'b1;
      OP_SBC: begin
        strobe.invertB = 1'b1;
        strobe.carryEn = 1'b1;
      end
      OP_AND: strobe.logicPath = 1'b1;
      OP_XOR: begin
        strobe.logicPath = 1'b1;
        strobe.logicFn   = LG_XOR;
      end
      OP_OR: begin
        strobe.logicPath = 1'b1;
        strobe.logicFn   = LG_OR;
      end
      OP_CMP: begin
        strobe.invertB = 1'b1;
        strobe.writeEn = 1'b0;
      end
      default: ;
    endcase
  end

endmodule

// File: rtl/accum_alu_dp.sv
`timescale 1ns/1ps
module accum_alu_dp
  import accum_alu_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  ctrlStrobe_t         strobe,
  input  logic [DATA_W-1:0]   accIn,
  input  logic [DATA_W-1:0]   opndIn,
  input  logic                carryIn,
  output logic [DATA_W-1:0]   resultOut,
  output logic [FLAG_W-1:0]   flagsOut
);

  localparam int MSB  = DATA_W - 1;
  localparam int HALF = DATA_W / 2;

  logic [DATA_W-1:0] bOp;
  logic              cinEff;
  logic              cinAdj;
  logic [DATA_W:0]   sumFull;
  logic [HALF:0]     sumLow;
  logic [DATA_W-1:0] arithRes;
  logic [DATA_W-1:0] logicRes;
  logic [DATA_W-1:0] calcRes;
  logic              carryBit;
  logic              halfBit;
  logic              ovfBit;

  // subtraction is acc + ~b + ~borrowIn; carry sense inverts on the way out
  always_comb begin
    bOp      = strobe.invertB ? ~opndIn : opndIn;
    cinEff   = strobe.carryEn & carryIn;
    cinAdj   = strobe.invertB ? ~cinEff : cinEff;
    sumFull  = {1'b0, accIn} + {1'b0, bOp} + (DATA_W+1)'(cinAdj);
    sumLow   = {1'b0, accIn[HALF-1:0]} + {1'b0, bOp[HALF-1:0]} + (HALF+1)'(cinAdj);
    arithRes = sumFull[DATA_W-1:0];
    carryBit = sumFull[DATA_W] ^ strobe.invertB;
    halfBit  = sumLow[HALF] ^ strobe.invertB;
    ovfBit   = (accIn[MSB] == bOp[MSB]) && (arithRes[MSB] != accIn[MSB]);
  end

  always_comb begin
    case (strobe.logicFn)
      LG_XOR:  logicRes = accIn ^ opndIn;
      LG_OR:   logicRes = accIn | opndIn;
      default: logicRes = accIn & opndIn;
    endcase
  end

  always_comb begin
    calcRes          = strobe.logicPath ? logicRes : arithRes;
    flagsOut         = '0;
    flagsOut[FLG_S]  = calcRes[MSB];
    flagsOut[FLG_Z]  = (calcRes == '0);
    flagsOut[FLG_H]  = strobe.logicPath ? (strobe.logicFn == LG_AND) : halfBit;
    flagsOut[FLG_PV] = strobe.logicPath ? ~^logicRes : ovfBit;
    flagsOut[FLG_N]  = strobe.invertB;
    flagsOut[FLG_C]  = strobe.logicPath ? 1'b0 : carryBit;
    resultOut        = strobe.writeEn ? calcRes : accIn;
  end

endmodule

// File: rtl/accum_alu.sv
`timescale 1ns/1ps
module accum_alu
  import accum_alu_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              inValid,
  input  logic [DATA_W-1:0] accIn,
  input  logic [DATA_W-1:0] opndIn,
  input  logic [2:0]        opSel,
  input  logic              carryIn,
  output logic              outValid,
  output logic [DATA_W-1:0] resultOut,
  output logic [FLAG_W-1:0] flagsOut,
  output logic              writeBack
);

  ctrlStrobe_t       strobe;
  logic [DATA_W-1:0] nextRes;
  logic [FLAG_W-1:0] nextFlags;

  accum_alu_ctrl u_ctrl (
    .opSel  (opSel),
    .strobe (strobe)
  );

  accum_alu_dp #(.DATA_W(DATA_W)) u_dp (
    .strobe    (strobe),
    .accIn     (accIn),
    .opndIn    (opndIn),
    .carryIn   (carryIn),
    .resultOut (nextRes),
    .flagsOut  (nextFlags)
  );

  always_ff @(posedge clk) begin
    if (!rstN) begin
      outValid  <= 1'b0;
      resultOut <= '0;
      flagsOut  <= '0;
      writeBack <= 1'b0;
    end else begin
      outValid <= inValid;
      if (inValid) begin
        resultOut <= nextRes;
        flagsOut  <= nextFlags;
        writeBack <= strobe.writeEn;
      end
    end
  end

endmodule

// File: rtl/accum_alu_chk.sv
`timescale 1ns/1ps
module accum_alu_chk #(
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rstN,
  input logic              inValid,
  input logic [2:0]        opSel,
  input logic              outValid,
  input logic [DATA_W-1:0] resultOut,
  input logic [7:0]        flagsOut,
  input logic              writeBack
);

  AST_VALID_LATENCY: assert property (@(posedge clk) disable iff (!rstN) inValid |=> outValid); // R11
  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rstN) !inValid |=> ($stable(resultOut) && $stable(flagsOut) && $stable(writeBack))); // R11
  AST_CMP_NO_WRITE: assert property (@(posedge clk) disable iff (!rstN) (outValid && $past(opSel) == 3'd7) |-> !writeBack); // R5
  AST_LOGIC_CARRY_CLEAR: assert property (@(posedge clk) disable iff (!rstN) (outValid && $past(opSel) inside {3'd4, 3'd5, 3'd6}) |-> !flagsOut[0]); // R4
  AST_LOGIC_PARITY: assert property (@(posedge clk) disable iff (!rstN) (outValid && $past(opSel) inside {3'd4, 3'd5, 3'd6}) |-> (flagsOut[2] == ~^resultOut)); // R4
  AST_SUBTRACT_FLAG: assert property (@(posedge clk) disable iff (!rstN) outValid |-> (flagsOut[1] == ($past(opSel) inside {3'd2, 3'd3, 3'd7}))); // R8
  AST_SIGN_ZERO: assert property (@(posedge clk) disable iff (!rstN) (outValid && writeBack) |-> (flagsOut[7] == resultOut[DATA_W-1] && flagsOut[6] == (resultOut == '0))); // R9
  AST_SPARE_BITS: assert property (@(posedge clk) disable iff (!rstN) (!flagsOut[5] && !flagsOut[3])); // R10

endmodule

bind accum_alu accum_alu_chk #(.DATA_W(DATA_W)) u_chk (
  .clk       (clk),
  .rstN      (rstN),
  .inValid   (inValid),
  .opSel     (opSel),
  .outValid  (outValid),
  .resultOut (resultOut),
  .flagsOut  (flagsOut),
  .writeBack (writeBack)
);

// File: tb/accum_alu_test.sv
`timescale 1ns/1ps
module accum_alu_test;

  localparam int PERIOD    = 20;
  localparam int WATCHDOG  = 200000;
  localparam int NUM_VEC   = 18;

  typedef struct packed {
    logic [2:0] op;
    logic [7:0] acc;
    logic [7:0] opnd;
    logic       cin;
    logic [7:0] expRes;
    logic [7:0] expFlg;
    logic       expWb;
  } vec_t;

  // flags: S=80 Z=40 H=10 PV=04 N=02 C=01
  localparam vec_t VECS [NUM_VEC] = '{
    '{3'd0, 8'h0F, 8'h01, 1'b1, 8'h10, 8'h10, 1'b1},
    '{3'd0, 8'h7F, 8'h01, 1'b0, 8'h80, 8'h94, 1'b1},
    '{3'd0, 8'hFF, 8'h01, 1'b0, 8'h00, 8'h51, 1'b1},
    '{3'd1, 8'h10, 8'h20, 1'b1, 8'h31, 8'h00, 1'b1},
    '{3'd1, 8'h7F, 8'h00, 1'b1, 8'h80, 8'h94, 1'b1},
    '{3'd1, 8'hF0, 8'h0F, 1'b1, 8'h00, 8'h51, 1'b1},
    '{3'd2, 8'h10, 8'h01, 1'b1, 8'h0F, 8'h12, 1'b1},
    '{3'd2, 8'h80, 8'h01, 1'b0, 8'h7F, 8'h16, 1'b1},
    '{3'd2, 8'h01, 8'h02, 1'b0, 8'hFF, 8'h93, 1'b1},
    '{3'd3, 8'h05, 8'h05, 1'b1, 8'hFF, 8'h93, 1'b1},
    '{3'd3, 8'h05, 8'h05, 1'b0, 8'h00, 8'h42, 1'b1},
    '{3'd4, 8'hF0, 8'h3C, 1'b1, 8'h30, 8'h14, 1'b1},
    '{3'd4, 8'h0F, 8'hF0, 1'b1, 8'h00, 8'h54, 1'b1},
    '{3'd5, 8'hFF, 8'h01, 1'b1, 8'hFE, 8'h80, 1'b1},
    '{3'd5, 8'h55, 8'h55, 1'b0, 8'h00, 8'h44, 1'b1},
    '{3'd6, 8'h01, 8'h02, 1'b1, 8'h03, 8'h04, 1'b1},
    '{3'd7, 8'h20, 8'h20, 1'b1, 8'h20, 8'h42, 1'b0},
    '{3'd7, 8'h10, 8'h20, 1'b0, 8'h10, 8'h83, 1'b0}
  };

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       inValid = 1'b0;
  logic [7:0] accIn = '0;
  logic [7:0] opndIn = '0;
  logic [2:0] opSel = '0;
  logic       carryIn = 1'b0;
  logic       outValid;
  logic [7:0] resultOut;
  logic [7:0] flagsOut;
  logic       writeBack;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  always #(PERIOD/2) clk = ~clk;

  accum_alu uut (
    .clk       (clk),
    .rstN      (rstN),
    .inValid   (inValid),
    .accIn     (accIn),
    .opndIn    (opndIn),
    .opSel     (opSel),
    .carryIn   (carryIn),
    .outValid  (outValid),
    .resultOut (resultOut),
    .flagsOut  (flagsOut),
    .writeBack (writeBack)
  );

  task automatic checkEq(input string tag, input string what,
                         input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %02h expected %02h", tag, what, act, exp);
    end
  endtask

  function automatic string tagOf(input logic [2:0] op);
    case (op)
      3'd0:          return "R1";
      3'd1:          return "R2";
      3'd2, 3'd3:    return "R3";
      3'd7:          return "R5";
      default:       return "R4";
    endcase
  endfunction

  task automatic issue(input logic [2:0] op, input logic [7:0] a,
                       input logic [7:0] b, input logic c);
    @(negedge clk);
    opSel = op; accIn = a; opndIn = b; carryIn = c; inValid = 1'b1;
    @(negedge clk);
    inValid = 1'b0;
  endtask

  initial begin
    #(PERIOD * WATCHDOG);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog: actual hung expected done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R12: reset state
    checkEq("R12", "outValid", {7'd0, outValid}, 8'h00);
    checkEq("R12", "result", resultOut, 8'h00);
    checkEq("R12", "flags", flagsOut, 8'h00);
    checkEq("R12", "writeBack", {7'd0, writeBack}, 8'h00);
    rstN = 1'b1;

    for (int i = 0; i < NUM_VEC; i++) begin
      vec_t v;
      v = VECS[i];
      issue(v.op, v.acc, v.opnd, v.cin);
      checkEq("R11", "outValid", {7'd0, outValid}, 8'h01);
      checkEq(tagOf(v.op), "result", resultOut, v.expRes);
      checkEq(tagOf(v.op), "carry", {7'd0, flagsOut[0]}, {7'd0, v.expFlg[0]});
      checkEq("R9", "sign/zero", {6'd0, flagsOut[7:6]}, {6'd0, v.expFlg[7:6]});
      checkEq("R7", "half", {7'd0, flagsOut[4]}, {7'd0, v.expFlg[4]});
      checkEq((v.op inside {3'd4, 3'd5, 3'd6}) ? "R4" : "R6", "parity/overflow",
              {7'd0, flagsOut[2]}, {7'd0, v.expFlg[2]});
      checkEq("R8", "subtract", {7'd0, flagsOut[1]}, {7'd0, v.expFlg[1]});
      checkEq("R10", "spare bits", flagsOut & 8'h28, 8'h00);
      checkEq("R5", "writeBack", {7'd0, writeBack}, {7'd0, v.expWb});
    end

    // R11: idle cycle with changed inputs leaves outputs alone
    issue(3'd0, 8'h12, 8'h34, 1'b0);
    @(negedge clk);
    opSel = 3'd6; accIn = 8'hFF; opndIn = 8'h00;
    @(negedge clk);
    checkEq("R11", "idle outValid", {7'd0, outValid}, 8'h00);
    checkEq("R11", "held result", resultOut, 8'h46);
    checkEq("R11", "held flags", flagsOut, 8'h00);

    // R1: add ignores carry-in at the top boundary
    issue(3'd0, 8'h80, 8'h80, 1'b1);
    checkEq("R1", "add 80+80 result", resultOut, 8'h00);
    checkEq("R1", "add 80+80 flags", flagsOut, 8'h45);

    // R12: reset after activity clears everything
    @(negedge clk);
    rstN = 1'b0;
    @(negedge clk);
    checkEq("R12", "post-reset outValid", {7'd0, outValid}, 8'h00);
    checkEq("R12", "post-reset result", resultOut, 8'h00);
    checkEq("R12", "post-reset flags", flagsOut, 8'h00);
    checkEq("R12", "post-reset writeBack", {7'd0, writeBack}, 8'h00);

    finished = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule